// File: doc/BRIEF.md
# Reference Clock Source Sequencer

This block sequences the start-up of the main reference clock, which can come from a crystal oscillator or from an on-chip RC oscillator. It turns register-style control bits into the enable strobes that go to the analog oscillator cells. It then decides when downstream digital logic may be clocked, and it reports two read-only status bits: one for power-up readiness and one for crystal health.

After the crystal is powered up, two independent timers start counting reference cycles from zero. The first is the settle wait. When it expires, the crystal is reported as ready to use. The second is the release wait. When it expires, the gated clock enable for internal logic is opened while the crystal is the selected source. A bypass bit forces that enable open. Selecting the RC source instead hands the enable to the RC on/off bit.

A separate detector can be armed to watch a liveness signal from the crystal cell through a synchronizer. Its result drives the crystal-OK status bit. Powering the crystal down clears all of this state at once.

Top module: `refclk_source_seq`

## Requirements
- R1: While `pwr_down_i` is 1, `ready_stat_o`, `xtal_ok_o` and `xo_pwr_en_o` all read 0 in the same cycle, with no register delay.
- R2: With `settle_code_i` = c, `ready_stat_o` rises on the (256·2^c)-th rising edge after `pwr_down_i` was sampled low, so code 0 gives 256 edges and code 3 gives 2048. It stays 0 on the edge before that.
- R3: With the crystal selected (`src_rc_i` = 0) and `gate_bypass_i` = 0, `clk_en_o` rises on the (16·(c+1))-th rising edge after power-up, where c is `release_code_i`.
- R4: With the crystal selected and `gate_bypass_i` = 1, `clk_en_o` is 1 whatever the release timer holds, including during power-down.
- R5: With `src_rc_i` = 1, `clk_en_o` equals `rc_on_i`. In particular it stays 0 when `rc_on_i` is 0, even if the crystal timers have expired. `rc_pwr_en_o` always equals `rc_on_i`.
- R6: `src_sel_o` equals `src_rc_i`, where 0 selects the crystal and 1 selects the RC oscillator.
- R7: The detector is armed when `okdet_en_i` = 1 and `pwr_down_i` = 0, and `okdet_arm_o` shows this armed state. While armed, `xtal_ok_o` goes to 1 two rising edges after `xtal_alive_i` is 1, and back to 0 two edges after it drops. When not armed, it reads 0 at once.
- R8: Asserting `pwr_down_i` during a count aborts it. After `pwr_down_i` clears, both waits restart from zero and run their full length.
- R9: `xo_gate_o` equals `gate_en_i` while the crystal is powered, and is 0 during power-down.
- R10: After synchronous reset, with `pwr_down_i` held at 1, `ready_stat_o`, `xtal_ok_o` and `clk_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down_i | input | 1 | 1 powers the crystal down |
| gate_en_i | input | 1 | Crystal output gate enable |
| okdet_en_i | input | 1 | Arms the crystal health detector |
| gate_bypass_i | input | 1 | Forces the internal clock enable open |
| settle_code_i | input | 2 | Settle wait code |
| release_code_i | input | 3 | Gate release wait code |
| src_rc_i | input | 1 | Source select: 0 crystal, 1 RC |
| rc_on_i | input | 1 | RC oscillator on |
| xtal_alive_i | input | 1 | Liveness indication from crystal cell |
| xo_pwr_en_o | output | 1 | Crystal power enable strobe |
| xo_gate_o | output | 1 | Crystal output gate strobe |
| okdet_arm_o | output | 1 | Detector enable strobe |
| rc_pwr_en_o | output | 1 | RC oscillator power strobe |
| clk_en_o | output | 1 | Gated clock enable for internal logic |
| src_sel_o | output | 1 | Clock source select |
| ready_stat_o | output | 1 | Crystal ready status |
| xtal_ok_o | output | 1 | Crystal health status |

## Verification
A settle counter that starts late, skips counts or fails to clear on power-down moves the rising edge of `ready_stat_o` off its exact cycle. The bench therefore samples one edge before and one edge on the expected count. A fault in the release timer or the source mux shows up the same way on `clk_en_o`, or as an enable that opens while the RC source is off. A synchronizer of the wrong depth shifts `xtal_ok_o` by one or more cycles, and stale state surviving a power-down shows up as an early `ready_stat_o` after restart.

// File: rtl/refclk_seq_pkg.sv
// Shared constants and wait-length helpers for the reference clock sequencer.
// Assumes all waits are counted in reference clock cycles.
package refclk_seq_pkg;

    // Clock source encoding seen on src_sel_o.
    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_RC   = 1'b1
    } src_e;

    // Number of independent wait timers.
    localparam int unsigned N_TIMERS  = 2;
    localparam int unsigned T_SETTLE  = 0;
    localparam int unsigned T_RELEASE = 1;

    // Settle wait: base length doubled per code step.
    function automatic int unsigned settle_len(input int unsigned base, input int unsigned code);
        settle_len = base << code;
    endfunction

    // Release wait: linear in code, one step per code value plus one.
    function automatic int unsigned release_len(input int unsigned step, input int unsigned code);
        release_len = step * (code + 1);
    endfunction

endpackage

// File: rtl/seq_delay_timer.sv
// Saturating up-counter that reports when a programmable limit is reached.
// Assumes the limit may change at any time; done tracks cnt >= limit.
module seq_delay_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Count up from zero after clear drops; hold once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry flag for the current limit.
    always_comb begin
        done = (cnt >= limit);
    end

endmodule

// File: rtl/seq_alive_sync.sv
// Synchronizer for the crystal liveness signal, held clear while disarmed.
// Assumes the input is asynchronous to clk; STAGES >= 1.
module seq_alive_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            // Single-flop capture of the liveness input.
            always_ff @(posedge clk) begin
                if (!rst_n || !armed) sr <= '0;
                else                  sr <= d_in;
            end
        end else begin : g_chain
            // Shift the liveness input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n || !armed) sr <= '0;
                else                  sr <= {sr[STAGES-2:0], d_in};
            end
        end
    endgenerate

    // Detector result, forced low while disarmed.
    always_comb begin
        q_out = armed & sr[STAGES-1];
    end

endmodule

// File: rtl/seq_clk_enable_sel.sv
// Chooses the downstream clock enable from the selected source.
// Assumes the crystal release flag is already qualified by power state.
module seq_clk_enable_sel
    import refclk_seq_pkg::*;
(
    input  src_e src,
    input  logic xtal_released,
    input  logic bypass,
    input  logic rc_on,
    output logic clk_en
);

    // Route the enable of the chosen source.
    always_comb begin
        unique case (src)
            SRC_RC:   clk_en = rc_on;
            default:  clk_en = bypass | xtal_released;
        endcase
    end

endmodule

// File: rtl/refclk_source_seq.sv
// Reference clock source sequencer: crystal power-up waits, gate release,
// source choice and status. Assumes control inputs are synchronous to clk
// except xtal_alive_i, which is synchronized here.
module refclk_source_seq
    import refclk_seq_pkg::*;
#(
    parameter int unsigned SETTLE_BASE = 256,
    parameter int unsigned GATE_STEP   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down_i,
    input  logic       gate_en_i,
    input  logic       okdet_en_i,
    input  logic       gate_bypass_i,
    input  logic [1:0] settle_code_i,
    input  logic [2:0] release_code_i,
    input  logic       src_rc_i,
    input  logic       rc_on_i,
    input  logic       xtal_alive_i,
    output logic       xo_pwr_en_o,
    output logic       xo_gate_o,
    output logic       okdet_arm_o,
    output logic       rc_pwr_en_o,
    output logic       clk_en_o,
    output logic       src_sel_o,
    output logic       ready_stat_o,
    output logic       xtal_ok_o
);

    localparam int unsigned MAX_SETTLE  = SETTLE_BASE << 3;
    localparam int unsigned MAX_RELEASE = GATE_STEP * 8;
    localparam int unsigned MAX_WAIT    = (MAX_SETTLE > MAX_RELEASE) ? MAX_SETTLE : MAX_RELEASE;
    localparam int unsigned CNT_W       = $clog2(MAX_WAIT + 1);

    logic [N_TIMERS-1:0][CNT_W-1:0] limits;
    logic [N_TIMERS-1:0]            expired;
    logic                           powered;
    logic                           armed;
    logic                           released;
    src_e                           src;

    // Power state and wait limits decoded from the codes.
    always_comb begin
        powered             = ~pwr_down_i;
        armed               = okdet_en_i & powered;
        limits[T_SETTLE]    = CNT_W'(settle_len(SETTLE_BASE, int'(settle_code_i)));
        limits[T_RELEASE]   = CNT_W'(release_len(GATE_STEP, int'(release_code_i)));
        src                 = src_e'(src_rc_i);
    end

    generate
        for (genvar t = 0; t < N_TIMERS; t++) begin : g_timer
            seq_delay_timer #(.CNT_W(CNT_W)) u_timer (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (pwr_down_i),
                .limit (limits[t]),
                .done  (expired[t])
            );
        end
    endgenerate

    seq_alive_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed),
        .d_in  (xtal_alive_i),
        .q_out (xtal_ok_o)
    );

    // Release flag qualified by the crystal being powered.
    always_comb begin
        released = expired[T_RELEASE] & powered;
    end

    seq_clk_enable_sel u_sel (
        .src           (src),
        .xtal_released (released),
        .bypass        (gate_bypass_i),
        .rc_on         (rc_on_i),
        .clk_en        (clk_en_o)
    );

    // Analog strobes and status outputs.
    always_comb begin
        xo_pwr_en_o  = powered;
        xo_gate_o    = gate_en_i & powered;
        okdet_arm_o  = armed;
        rc_pwr_en_o  = rc_on_i;
        src_sel_o    = src_rc_i;
        ready_stat_o = expired[T_SETTLE] & powered;
    end

endmodule

// File: rtl/refclk_source_seq_chk.sv
// Property checker for the reference clock sequencer, bound to the top.
module refclk_source_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_down_i,
    input logic       gate_en_i,
    input logic       okdet_en_i,
    input logic       gate_bypass_i,
    input logic [1:0] settle_code_i,
    input logic [2:0] release_code_i,
    input logic       src_rc_i,
    input logic       rc_on_i,
    input logic       xtal_alive_i,
    input logic       xo_pwr_en_o,
    input logic       xo_gate_o,
    input logic       okdet_arm_o,
    input logic       rc_pwr_en_o,
    input logic       clk_en_o,
    input logic       src_sel_o,
    input logic       ready_stat_o,
    input logic       xtal_ok_o
);

    a_r1_pd_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |-> (!ready_stat_o && !xtal_ok_o && !xo_pwr_en_o));

    a_r8_restart_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down_i) |-> !ready_stat_o);

    a_r4_bypass_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_rc_i && gate_bypass_i) |-> clk_en_o);

    a_r5_rc_off_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rc_i && !rc_on_i) |-> !clk_en_o);

    a_r3_release_after_power: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o && !src_rc_i && !gate_bypass_i) |-> $past(!pwr_down_i));

    a_r7_ok_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_ok_o |-> okdet_arm_o);

endmodule

bind refclk_source_seq refclk_source_seq_chk u_chk (.*);

// File: tb/tb_refclk_source_seq.sv
module tb_refclk_source_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_down_i, gate_en_i, okdet_en_i, gate_bypass_i;
    logic [1:0] settle_code_i;
    logic [2:0] release_code_i;
    logic       src_rc_i, rc_on_i, xtal_alive_i;
    logic       xo_pwr_en_o, xo_gate_o, okdet_arm_o, rc_pwr_en_o;
    logic       clk_en_o, src_sel_o, ready_stat_o, xtal_ok_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refclk_source_seq dut (.*);

    task automatic chk(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Hold power-down a few cycles, then release on a falling edge.
    task automatic power_cycle();
        pwr_down_i = 1'b1;
        edges(3);
        pwr_down_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pwr_down_i = 1'b1; gate_en_i = 1'b0; okdet_en_i = 1'b1;
        gate_bypass_i = 1'b0; settle_code_i = 2'd0; release_code_i = 3'd0;
        src_rc_i = 1'b0; rc_on_i = 1'b0; xtal_alive_i = 1'b1;
        edges(4);
        rst_n = 1'b1;
        edges(1);
        chk("R10 ready after reset", ready_stat_o, 1'b0);
        chk("R10 ok after reset", xtal_ok_o, 1'b0);
        chk("R10 clk_en after reset", clk_en_o, 1'b0);
    endtask

    // Settle and release waits measured on their exact edges.
    task automatic t_waits(input logic [1:0] sc, input logic [2:0] rc);
        int s_len = 256 << sc;
        int r_len = 16 * (rc + 1);
        settle_code_i = sc; release_code_i = rc;
        okdet_en_i = 1'b0; gate_bypass_i = 1'b0; src_rc_i = 1'b0;
        power_cycle();
        edges(r_len - 1);
        chk("R3 clk_en before release", clk_en_o, 1'b0);
        edges(1);
        chk("R3 clk_en on release", clk_en_o, 1'b1);
        edges(s_len - r_len - 1);
        chk("R2 ready before settle", ready_stat_o, 1'b0);
        edges(1);
        chk("R2 ready on settle", ready_stat_o, 1'b1);
    endtask

    task automatic t_powerdown();
        okdet_en_i = 1'b1; xtal_alive_i = 1'b1; gate_en_i = 1'b1;
        edges(3);
        chk("R9 gate strobe powered", xo_gate_o, 1'b1);
        chk("R7 ok while armed", xtal_ok_o, 1'b1);
        pwr_down_i = 1'b1;
        #1;
        chk("R1 ready in power-down", ready_stat_o, 1'b0);
        chk("R1 ok in power-down", xtal_ok_o, 1'b0);
        chk("R1 xtal power strobe", xo_pwr_en_o, 1'b0);
        chk("R9 gate strobe in power-down", xo_gate_o, 1'b0);
        edges(1);
    endtask

    task automatic t_abort();
        settle_code_i = 2'd0; okdet_en_i = 1'b0;
        power_cycle();
        edges(200);
        power_cycle();
        edges(255);
        chk("R8 restarted wait not done", ready_stat_o, 1'b0);
        edges(1);
        chk("R8 restarted wait full length", ready_stat_o, 1'b1);
    endtask

    task automatic t_bypass();
        pwr_down_i = 1'b1; src_rc_i = 1'b0; gate_bypass_i = 1'b1;
        edges(1);
        chk("R4 bypass opens enable", clk_en_o, 1'b1);
        gate_bypass_i = 1'b0;
        edges(1);
        chk("R4 no bypass closed in power-down", clk_en_o, 1'b0);
    endtask

    task automatic t_rc();
        release_code_i = 3'd0;
        power_cycle();
        edges(20);
        chk("R3 crystal released", clk_en_o, 1'b1);
        src_rc_i = 1'b1; rc_on_i = 1'b0;
        edges(1);
        chk("R5 rc off keeps enable low", clk_en_o, 1'b0);
        chk("R5 rc power strobe off", rc_pwr_en_o, 1'b0);
        chk("R6 select rc", src_sel_o, 1'b1);
        rc_on_i = 1'b1;
        edges(1);
        chk("R5 rc on opens enable", clk_en_o, 1'b1);
        chk("R5 rc power strobe on", rc_pwr_en_o, 1'b1);
        src_rc_i = 1'b0;
        edges(1);
        chk("R6 select crystal", src_sel_o, 1'b0);
    endtask

    task automatic t_okdet();
        pwr_down_i = 1'b0; okdet_en_i = 1'b0; xtal_alive_i = 1'b1;
        edges(5);
        chk("R7 disarmed ok low", xtal_ok_o, 1'b0);
        chk("R7 arm strobe low", okdet_arm_o, 1'b0);
        okdet_en_i = 1'b1;
        edges(1);
        chk("R7 ok one edge after arm", xtal_ok_o, 1'b0);
        chk("R7 arm strobe high", okdet_arm_o, 1'b1);
        edges(1);
        chk("R7 ok two edges after arm", xtal_ok_o, 1'b1);
        xtal_alive_i = 1'b0;
        edges(1);
        chk("R7 ok held one edge", xtal_ok_o, 1'b1);
        edges(1);
        chk("R7 ok drops two edges", xtal_ok_o, 1'b0);
    endtask

    initial begin
        t_reset();
        t_waits(2'd0, 3'd0);
        t_waits(2'd1, 3'd7);
        t_waits(2'd3, 3'd3);
        t_powerdown();
        t_abort();
        t_bypass();
        t_rc();
        t_okdet();
        summary();
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            summary();
        end
    end

endmodule